// File: doc/BRIEF.md
# I2C-over-auxiliary-channel packet codec

This block sits between an I2C transfer engine and a packetised auxiliary-channel transmitter and receiver. On the request side it takes one I2C command and turns it into the byte sequence of a request packet. The command is write, read or status request. It comes with a middle-of-transaction flag, a 7-bit target address and, optionally, a transfer length. The block sends one byte per clock and pulls write data from the caller while it sends the data bytes. Requests it cannot encode are refused with a one-cycle error strobe, and nothing is sent for them.

On the reply side it watches the incoming byte stream. It decodes the first byte of each reply into an auxiliary-level status and an I2C-level status, and it flags headers that do not follow the layout. It forwards the bytes after the header as data only when the reply was acknowledged at both levels. Line coding, timeouts and retries belong to the surrounding logic.

The request side is a six-state machine:
- `S_IDLE`: waits for a request and checks it.
- `S_HDR`: sends the header byte.
- `S_ZERO`: sends the zero byte.
- `S_ADDR`: sends the address byte.
- `S_LEN`: sends the length byte.
- `S_DATA`: sends the write data.

Its transitions are:
- accept: `S_IDLE`→`S_HDR`.
- reject: stay in `S_IDLE` and strobe the error.
- `S_HDR`→`S_ZERO`→`S_ADDR`.
- addr_done: `S_ADDR`→`S_IDLE` when there is no length, otherwise →`S_LEN`.
- len_done: `S_LEN`→`S_IDLE` for read and status, →`S_DATA` for write.
- data_loop: `S_DATA` stays in `S_DATA`, then goes →`S_IDLE` after the last byte.

The reply side has two states:
- `R_IDLE`: body bytes are dropped.
- `R_BODY`: body bytes are forwarded.

A header moves the reply side to `R_BODY` only when both levels acknowledged. Any other header moves it back to `R_IDLE`.

Top module: `aux_i2c_codec`

## Requirements
- R1: The first three bytes of an accepted request are sent on consecutive cycles, starting the cycle after the request is sampled:
  - the header `{1'b0, mot, cmd[1:0], 4'b0000}`;
  - then `8'h00`;
  - then `{1'b0, addr[6:0]}`.
  - Command codes are 0 write, 1 read, 2 status request and 3 reserved.
- R2: A request with `req_has_len`=0 is exactly three bytes long. `tx_last` is high only with the third byte, and `tx_valid` is low in the cycle after it.
- R3: A request with `req_has_len`=1 sends a fourth byte equal to `req_len`-1, held in the low bits with the upper bits zero. For read and status commands this byte is the last one.
- R4: A write request with `req_has_len`=1 sends `req_len` data bytes straight after the length byte. Each data byte equals `wr_data` in the same cycle, with `wr_pull` high. The last data byte carries `tx_last`.
- R5: A request is rejected if its command is 3, or if `req_has_len`=1 with `req_len` of 0 or greater than 16. On rejection `req_err` is high for exactly the next cycle and no byte is sent.
- R6: A `req_valid` that arrives while `busy` is high is ignored. No error is raised, and the bytes being sent are unchanged.
- R7: The cycle after a reply byte is taken with `rx_first`=1, `rep_hdr_valid` pulses.
  - `rep_aux_st` shows header bits 5:4: 0 ACK, 1 NACK, 2 DEFER, 3 reserved.
  - `rep_i2c_st` shows bits 7:6 when the auxiliary status is ACK, and 0 otherwise.
- R8: `rep_bad` is set with the header pulse in any of these cases:
  - the auxiliary status is 3;
  - header bits 3:0 are nonzero;
  - bits 7:6 are nonzero while the auxiliary status is not ACK;
  - bits 7:6 equal 3 while it is ACK.
- R9: A reply byte with `rx_first`=0 is forwarded on `rep_data` with `rep_data_valid`, one cycle later, only if the latest header was well formed with both statuses ACK. Otherwise it is dropped, and that includes bytes arriving before any header.
- R10: After reset, `tx_valid`, `busy`, `req_err`, `rep_hdr_valid` and `rep_data_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_cmd | input | 2 | Command code |
| req_mot | input | 1 | Middle-of-transaction flag |
| req_addr | input | 7 | I2C target address |
| req_has_len | input | 1 | Request carries a length byte |
| req_len | input | 5 | Number of data bytes, 1 to 16 |
| wr_data | input | 8 | Write data for the current data byte |
| wr_pull | output | 1 | `wr_data` is consumed this cycle |
| tx_valid | output | 1 | Request byte valid |
| tx_byte | output | 8 | Request byte |
| tx_last | output | 1 | Final byte of the request |
| busy | output | 1 | Request in progress |
| req_err | output | 1 | Request rejected |
| rx_valid | input | 1 | Reply byte valid |
| rx_first | input | 1 | Reply byte is the header |
| rx_byte | input | 8 | Reply byte |
| rep_hdr_valid | output | 1 | Header decoded |
| rep_aux_st | output | 2 | Auxiliary status of the latest header |
| rep_i2c_st | output | 2 | I2C status of the latest header |
| rep_bad | output | 1 | Latest header malformed |
| rep_data_valid | output | 1 | Reply data byte valid |
| rep_data | output | 8 | Reply data byte |

## Verification
A request-side state that skips or repeats a step shows up within a few cycles of a request. It appears as a missing, doubled or misplaced byte, or as `tx_last` on the wrong byte. The bench compares every byte position against a model of the packet, so a wrong byte count is caught at the first mismatch. A reply-side state stuck in the wrong mode shows one cycle after the first body byte: a forwarded byte after a NACK, DEFER or malformed header, or a byte lost after a good one. The bench mixes random headers with the exact boundary codes to expose these cases.

// File: rtl/aux_codec_pkg.sv
package aux_codec_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        CMD_WR  = 2'd0,
        CMD_RD  = 2'd1,
        CMD_ST  = 2'd2,
        CMD_RSV = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_ACK   = 2'd0,
        ST_NACK  = 2'd1,
        ST_DEFER = 2'd2,
        ST_RSV   = 2'd3
    } status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_ZERO,
        S_ADDR,
        S_LEN,
        S_DATA
    } tx_state_e;

    typedef enum logic {
        R_IDLE,
        R_BODY
    } rx_state_e;
endpackage

// File: rtl/aux_req_builder.sv
module aux_req_builder
    import aux_codec_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic              req_mot,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_has_len,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              wr_pull,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_last,
    output logic              busy,
    output logic              req_err
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    tx_state_e         state_q, state_d;
    cmd_e              cmd_q;
    logic              mot_q;
    logic [ADDR_W-1:0] addr_q;
    logic              has_len_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              err_q;
    logic              req_bad;
    logic              accept;

    always_comb begin
        req_bad = (req_cmd == CMD_RSV) ||
                  (req_has_len && ((req_len == '0) || (req_len > LEN_MAX)));
        accept  = (state_q == S_IDLE) && req_valid && !req_bad;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = S_HDR;
            S_HDR:  state_d = S_ZERO;
            S_ZERO: state_d = S_ADDR;
            S_ADDR: state_d = has_len_q ? S_LEN : S_IDLE;
            S_LEN:  state_d = (cmd_q == CMD_WR) ? S_DATA : S_IDLE;
            S_DATA: state_d = (cnt_q == len_q - LEN_ONE) ? S_IDLE : S_DATA;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and captured request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            cmd_q     <= CMD_WR;
            mot_q     <= 1'b0;
            addr_q    <= '0;
            has_len_q <= 1'b0;
            len_q     <= '0;
            cnt_q     <= '0;
            err_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= (state_q == S_IDLE) && req_valid && req_bad;
            if (accept) begin
                cmd_q     <= cmd_e'(req_cmd);
                mot_q     <= req_mot;
                addr_q    <= req_addr;
                has_len_q <= req_has_len;
                len_q     <= req_len;
                cnt_q     <= '0;
            end else if (state_q == S_DATA) begin
                cnt_q <= cnt_q + LEN_ONE;
            end
        end
    end

    // outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_byte  = '0;
        tx_last  = 1'b0;
        wr_pull  = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_HDR: begin
                tx_valid = 1'b1;
                tx_byte  = {1'b0, mot_q, cmd_q, 4'b0000};
            end
            S_ZERO: begin
                tx_valid = 1'b1;
            end
            S_ADDR: begin
                tx_valid = 1'b1;
                tx_byte  = BYTE_W'(addr_q);
                tx_last  = !has_len_q;
            end
            S_LEN: begin
                tx_valid = 1'b1;
                tx_byte  = BYTE_W'(len_q - LEN_ONE);
                tx_last  = (cmd_q != CMD_WR);
            end
            S_DATA: begin
                tx_valid = 1'b1;
                tx_byte  = wr_data;
                wr_pull  = 1'b1;
                tx_last  = (cnt_q == len_q - LEN_ONE);
            end
            default: ;
        endcase
    end

    assign busy    = (state_q != S_IDLE);
    assign req_err = err_q;

    p_last_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_last) |=> !tx_valid);

    p_data_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DATA) |-> (cnt_q < len_q));

    p_err_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !tx_valid);

    p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> !req_err);

    p_hdr_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (tx_valid && !tx_last && !wr_pull));
endmodule

// File: rtl/aux_rep_decoder.sv
module aux_rep_decoder
    import aux_codec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_first,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rep_hdr_valid,
    output logic [1:0]        rep_aux_st,
    output logic [1:0]        rep_i2c_st,
    output logic              rep_bad,
    output logic              rep_data_valid,
    output logic [BYTE_W-1:0] rep_data
);
    rx_state_e   state_q, state_d;
    logic [1:0]  aux_d, i2c_d, top_bits;
    logic        bad_d, hdr_in, body_in;

    // header field decode
    always_comb begin
        hdr_in   = rx_valid && rx_first;
        body_in  = rx_valid && !rx_first;
        aux_d    = rx_byte[5:4];
        top_bits = rx_byte[7:6];
        i2c_d    = (aux_d == ST_ACK) ? top_bits : 2'b00;
        bad_d    = (aux_d == ST_RSV) || (rx_byte[3:0] != 4'b0000) ||
                   ((aux_d != ST_ACK) && (top_bits != 2'b00)) ||
                   ((aux_d == ST_ACK) && (top_bits == ST_RSV));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_IDLE, R_BODY: begin
                if (hdr_in)
                    state_d = (!bad_d && aux_d == ST_ACK && i2c_d == ST_ACK)
                              ? R_BODY : R_IDLE;
            end
            default: state_d = R_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= R_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_hdr_valid  <= 1'b0;
            rep_aux_st     <= 2'b00;
            rep_i2c_st     <= 2'b00;
            rep_bad        <= 1'b0;
            rep_data_valid <= 1'b0;
            rep_data       <= '0;
        end else begin
            rep_hdr_valid  <= hdr_in;
            rep_data_valid <= body_in && (state_q == R_BODY);
            if (hdr_in) begin
                rep_aux_st <= aux_d;
                rep_i2c_st <= i2c_d;
                rep_bad    <= bad_d;
            end
            if (body_in) rep_data <= rx_byte;
        end
    end

    p_i2c_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_hdr_valid && rep_aux_st != ST_ACK) |-> (rep_i2c_st == 2'b00));

    p_rsv_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_hdr_valid && rep_aux_st == ST_RSV) |-> rep_bad);

    p_data_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rep_data_valid |-> (!rep_bad && rep_aux_st == ST_ACK && rep_i2c_st == ST_ACK));

    p_hdr_no_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rep_hdr_valid |-> !rep_data_valid);
endmodule

// File: rtl/aux_i2c_codec.sv
module aux_i2c_codec
    import aux_codec_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic              req_mot,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_has_len,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        wr_data,
    output logic              wr_pull,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              tx_last,
    output logic              busy,
    output logic              req_err,
    input  logic              rx_valid,
    input  logic              rx_first,
    input  logic [7:0]        rx_byte,
    output logic              rep_hdr_valid,
    output logic [1:0]        rep_aux_st,
    output logic [1:0]        rep_i2c_st,
    output logic              rep_bad,
    output logic              rep_data_valid,
    output logic [7:0]        rep_data
);
    aux_req_builder #(
        .ADDR_W (ADDR_W),
        .MAX_LEN(MAX_LEN),
        .LEN_W  (LEN_W)
    ) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_cmd    (req_cmd),
        .req_mot    (req_mot),
        .req_addr   (req_addr),
        .req_has_len(req_has_len),
        .req_len    (req_len),
        .wr_data    (wr_data),
        .wr_pull    (wr_pull),
        .tx_valid   (tx_valid),
        .tx_byte    (tx_byte),
        .tx_last    (tx_last),
        .busy       (busy),
        .req_err    (req_err)
    );

    aux_rep_decoder u_rep (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_valid      (rx_valid),
        .rx_first      (rx_first),
        .rx_byte       (rx_byte),
        .rep_hdr_valid (rep_hdr_valid),
        .rep_aux_st    (rep_aux_st),
        .rep_i2c_st    (rep_i2c_st),
        .rep_bad       (rep_bad),
        .rep_data_valid(rep_data_valid),
        .rep_data      (rep_data)
    );

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (!tx_valid && !busy && !req_err && !rep_hdr_valid && !rep_data_valid));
endmodule

// File: tb/tb_aux_i2c_codec.sv
module tb_aux_i2c_codec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_cmd = '0;
    logic       req_mot = 1'b0;
    logic [6:0] req_addr = '0;
    logic       req_has_len = 1'b0;
    logic [4:0] req_len = '0;
    logic [7:0] wr_data = '0;
    logic       wr_pull, tx_valid, tx_last, busy, req_err;
    logic [7:0] tx_byte;
    logic       rx_valid = 1'b0, rx_first = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rep_hdr_valid, rep_bad, rep_data_valid;
    logic [1:0] rep_aux_st, rep_i2c_st;
    logic [7:0] rep_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] pay [16];

    always #5 clk = ~clk;

    aux_i2c_codec dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit bad_req(input logic [1:0] c, input bit hl, input int n);
        return (c == 2'd3) || (hl && (n == 0 || n > 16));
    endfunction

    function automatic int req_nbytes(input logic [1:0] c, input bit hl, input int n);
        if (!hl) return 3;
        if (c == 2'd0) return 4 + n;
        return 4;
    endfunction

    function automatic logic [7:0] req_exp(input int i, input logic [1:0] c, input bit m,
                                           input logic [6:0] a, input int n);
        case (i)
            0: return {1'b0, m, c, 4'b0000};
            1: return 8'h00;
            2: return {1'b0, a};
            3: return 8'(n - 1);
            default: return pay[i-4];
        endcase
    endfunction

    // issue a request and check every byte; inj: inject a request while busy
    task automatic run_req(input logic [1:0] c, input bit m, input logic [6:0] a,
                           input bit hl, input int n, input bit inj);
        int nb;
        nb = req_nbytes(c, hl, n);
        for (int k = 0; k < 16; k++) pay[k] = 8'($urandom);
        @(negedge clk);
        req_valid = 1; req_cmd = c; req_mot = m; req_addr = a;
        req_has_len = hl; req_len = 5'(n);
        @(negedge clk);
        req_valid = 0;
        if (bad_req(c, hl, n)) begin
            chk(req_err == 1 && tx_valid == 0, "R5 reject", {req_err, tx_valid}, 2);
            @(negedge clk);
            chk(req_err == 0 && tx_valid == 0 && busy == 0, "R5 no output", {req_err, tx_valid}, 0);
            return;
        end
        for (int i = 0; i < nb; i++) begin
            if (inj && i == 1) begin req_valid = 1; req_cmd = 2'd3; end
            if (inj && i == 2) req_valid = 0;
            wr_data = (i >= 4) ? pay[i-4] : 8'hA5;
            #1;
            chk(tx_valid && tx_byte == req_exp(i, c, m, a, n),
                (i < 3) ? "R1 byte" : (i == 3 ? "R3 len byte" : "R4 data byte"),
                tx_byte, req_exp(i, c, m, a, n));
            chk(tx_last == (i == nb - 1), hl ? "R3 last" : "R2 last", tx_last, (i == nb - 1));
            chk(wr_pull == (i >= 4), "R4 pull", wr_pull, (i >= 4));
            if (inj && i == 2) chk(req_err == 0, "R6 busy ignored", req_err, 0);
            @(negedge clk);
        end
        req_valid = 0;
        chk(!tx_valid && !req_err, "R2 end of packet", tx_valid, 0);
    endtask

    task automatic run_rep(input logic [7:0] h, input int nd);
        logic [1:0] ea, ei;
        bit eb, pass;
        logic [7:0] prev;
        ea = h[5:4];
        ei = (ea == 0) ? h[7:6] : 2'b00;
        eb = (ea == 3) || (h[3:0] != 0) || (ea != 0 && h[7:6] != 0) || (ea == 0 && h[7:6] == 3);
        pass = !eb && ea == 0 && ei == 0;
        @(negedge clk);
        rx_valid = 1; rx_first = 1; rx_byte = h;
        @(negedge clk);
        rx_first = 0;
        chk(rep_hdr_valid && rep_aux_st == ea && rep_i2c_st == ei, "R7 decode",
            {rep_aux_st, rep_i2c_st}, {ea, ei});
        chk(rep_bad == eb, "R8 malformed", rep_bad, eb);
        prev = 0;
        for (int k = 0; k <= nd; k++) begin
            if (k > 0) begin
                chk(rep_data_valid == pass && (!pass || rep_data == prev), "R9 body",
                    {rep_data_valid, rep_data}, {pass, prev});
            end
            if (k < nd) begin
                prev = 8'($urandom); rx_valid = 1; rx_byte = prev;
            end else rx_valid = 0;
            @(negedge clk);
        end
        rx_valid = 0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!tx_valid && !busy && !req_err && !rep_hdr_valid && !rep_data_valid,
            "R10 reset", {tx_valid, busy, req_err}, 0);
        rst_n = 1;
        // R9: body byte before any header is dropped
        @(negedge clk); rx_valid = 1; rx_first = 0; rx_byte = 8'h5A;
        @(negedge clk); rx_valid = 0;
        chk(!rep_data_valid, "R9 no header yet", rep_data_valid, 0);
        // directed requests
        run_req(2'd0, 1, 7'h50, 0, 0, 0);   // R2 address-only write
        run_req(2'd1, 0, 7'h50, 1, 1, 0);   // R3 read length 1
        run_req(2'd0, 1, 7'h3C, 1, 16, 0);  // R4 max write
        run_req(2'd0, 0, 7'h11, 1, 4, 1);   // R6 inject while busy
        run_req(2'd3, 0, 7'h20, 0, 0, 0);   // R5 reserved command
        run_req(2'd0, 0, 7'h20, 1, 0, 0);   // R5 zero length
        run_req(2'd1, 0, 7'h20, 1, 17, 0);  // R5 too long
        run_req(2'd2, 1, 7'h7F, 1, 2, 0);   // R3 status request
        // directed replies
        run_rep(8'h00, 3);  // full ACK
        run_rep(8'h40, 2);  // I2C NACK
        run_rep(8'h80, 2);  // I2C DEFER
        run_rep(8'h10, 2);  // AUX NACK
        run_rep(8'h20, 1);  // AUX DEFER
        run_rep(8'h30, 1);  // reserved aux
        run_rep(8'h50, 1);  // top bits on non-ACK
        run_rep(8'hC0, 1);  // reserved i2c
        run_rep(8'h01, 1);  // low bits set
        run_rep(8'h00, 2);
        // random mix
        for (int t = 0; t < 40; t++) begin
            run_req(2'($urandom), 1'($urandom), 7'($urandom), 1'($urandom),
                    int'($urandom % 19), 1'($urandom));
            run_rep(($urandom % 2) ? 8'($urandom) : {2'($urandom), 2'($urandom), 4'b0}, $urandom % 4);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule